// File: doc/BRIEF.md
# Threshold-Gated Cell Flow Controller

This block moves whole ATM cells from a set of small input cell queues to the output cell queues paired with them. Each pair has a programmable threshold. When the output queue of a pair holds more cells than that threshold, the pair is put on hold, and no new cell leaves its input queue. The hold is released only when the output level drops strictly below the threshold. When the level equals the threshold, the pair keeps whatever state it already has.

Among the pairs that are not held, have a complete cell ready and have an output queue able to take a push, a round-robin arbiter picks one. That cell then moves one word per cycle, for a fixed number of words. A cell that has started always finishes. Each pair counts the cells that arrive at its input queue and the cells delivered to its output queue. A small register port gives access to the thresholds and to the counters.

The last pair (index NPAIR-1) has a wide threshold field. Every other pair has a narrow one.

Top module: `cell_gate_ctrl`

## Requirements
- R1: After reset, every narrow threshold reads 15 and the wide threshold reads 63. All counters read 0, no pair is held, and `in_pop` and `out_push` are all zero.
- R2: The register address splits into a group field `reg_addr[AW-1:IW]` and a pair index `reg_addr[IW-1:0]`, with IW = clog2(NPAIR). The groups are: 0 = threshold, 1 = arrival counter, 2 = departure counter. `reg_rdata` returns the addressed value in the same cycle.
- R3: When a pair's `out_level` is greater than its threshold, the pair is held from the following cycle on.
- R4: A held pair is released in the cycle after its `out_level` falls below its threshold. While the level equals the threshold, the pair keeps its held or released state.
- R5: No cell transfer starts from a pair that was held, or whose `out_full` was high, in the cycle in which the choice was made.
- R6: A cell lasts exactly CELL_WORDS consecutive cycles. In each of these cycles the chosen pair has `in_pop` and `out_push` high, and `out_data` equals that pair's `in_data` word. The cell completes even if its pair becomes held or full partway through it.
- R7: Only one cell moves at a time, with at least one idle cycle between cells. When several pairs are eligible, the grant goes round-robin, starting after the pair served last.
- R8: The arrival counter adds one for every cycle in which `in_arrive` is high for that pair. The departure counter adds one for every completed cell. Both counters are 16 bits wide and wrap.
- R9: A write to a counter address clears that counter. A write to a threshold address loads the low 4 bits for a narrow pair and the low 6 bits for the wide pair.
- R10: A threshold write, or a level change, on one pair has no effect on the hold state or the transfers of any other pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_rdy | input | NPAIR | Input queue holds at least one complete cell |
| in_arrive | input | NPAIR | One complete cell accepted into the input queue this cycle |
| in_data | input | NPAIR*DW | Head word of each input queue |
| in_pop | output | NPAIR | Take one word from the input queue |
| out_full | input | NPAIR | Output queue cannot accept a new cell |
| out_level | input | NPAIR*WIDE_W | Output queue fill level in cells |
| out_push | output | NPAIR | Write one word to the output queue |
| out_data | output | DW | Word being moved |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | IW+2 | Register address (group, pair) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data |

## Verification
The bench builds the block with five pairs, 8-bit words and 4-word cells. With cells that short, multi-cell backlogs, releases of a hold and round-robin sequences all fit in a few dozen cycles. The bench can also raise a pair's level in the middle of a cell and see that cell finish.

Thresholds are exercised at 0, at the narrow maximum 15 and on the wide pair at 40 and 63. This covers the level-equals-threshold case and the case where a threshold of 0 can never release its pair.

// File: rtl/cfc_pkg.sv
package cfc_pkg;
    localparam int CNT_W = 16;

    typedef enum logic {
        XF_IDLE,
        XF_MOVE
    } xfer_e;
endpackage

// File: rtl/cfc_pair_gate.sv
// Per-pair state: threshold, hold flag with hysteresis, arrival and departure counters.
module cfc_pair_gate #(
    parameter int LVL_W = 6,
    parameter int THR_W = 4,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             thr_we,
    input  logic             arr_clr,
    input  logic             dep_clr,
    input  logic [LVL_W-1:0] thr_wdata,
    input  logic [LVL_W-1:0] level,
    input  logic             arrive,
    input  logic             depart,
    output logic             hold,
    output logic [LVL_W-1:0] thr,
    output logic [CNT_W-1:0] arr_cnt,
    output logic [CNT_W-1:0] dep_cnt
);
    localparam logic [THR_W-1:0] THR_MAX = '1;

    typedef struct packed {
        logic             hold;
        logic [THR_W-1:0] thr;
        logic [CNT_W-1:0] arr;
        logic [CNT_W-1:0] dep;
    } gate_t;

    gate_t            st_d, st_q;
    logic [LVL_W-1:0] thr_ext;

    always_comb begin
        st_d    = st_q;
        thr_ext = LVL_W'(st_q.thr);
        if (thr_we) st_d.thr = thr_wdata[THR_W-1:0];
        // hysteresis: set above, clear below, keep on equal
        if (level > thr_ext)      st_d.hold = 1'b1;
        else if (level < thr_ext) st_d.hold = 1'b0;
        if (arr_clr)     st_d.arr = '0;
        else if (arrive) st_d.arr = st_q.arr + 1'b1;
        if (dep_clr)     st_d.dep = '0;
        else if (depart) st_d.dep = st_q.dep + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.hold <= 1'b0;
            st_q.thr  <= THR_MAX;
            st_q.arr  <= '0;
            st_q.dep  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold    = st_q.hold;
    assign thr     = thr_ext;
    assign arr_cnt = st_q.arr;
    assign dep_cnt = st_q.dep;
endmodule

// File: rtl/cfc_rr_pick.sv
// Round-robin choice: first requester after the last granted index.
module cfc_rr_pick #(
    parameter int N  = 5,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] last,
    output logic          valid,
    output logic [IW-1:0] idx
);
    int c;

    always_comb begin
        valid = 1'b0;
        idx   = '0;
        c     = 0;
        for (int k = 1; k <= N; k++) begin
            c = (int'(last) + k) % N;
            if (!valid && req[c]) begin
                valid = 1'b1;
                idx   = IW'(c);
            end
        end
    end
endmodule

// File: rtl/cell_gate_ctrl.sv
module cell_gate_ctrl
    import cfc_pkg::*;
#(
    parameter int NPAIR      = 5,
    parameter int DW         = 8,
    parameter int CELL_WORDS = 53,
    parameter int NARROW_W   = 4,
    parameter int WIDE_W     = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NPAIR-1:0]        in_rdy,
    input  logic [NPAIR-1:0]        in_arrive,
    input  logic [NPAIR*DW-1:0]     in_data,
    output logic [NPAIR-1:0]        in_pop,
    input  logic [NPAIR-1:0]        out_full,
    input  logic [NPAIR*WIDE_W-1:0] out_level,
    output logic [NPAIR-1:0]        out_push,
    output logic [DW-1:0]           out_data,
    input  logic                    reg_we,
    input  logic [$clog2(NPAIR)+1:0] reg_addr,
    input  logic [15:0]             reg_wdata,
    output logic [15:0]             reg_rdata
);
    localparam int LVL_W = WIDE_W;
    localparam int IW    = $clog2(NPAIR);
    localparam int AW    = IW + 2;
    localparam int WC_W  = $clog2(CELL_WORDS + 1);
    localparam logic [WC_W-1:0] LAST_WORD = WC_W'(CELL_WORDS - 1);

    typedef struct packed {
        xfer_e           st;
        logic [IW-1:0]   sel;
        logic [IW-1:0]   last;
        logic [WC_W-1:0] wc;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NPAIR-1:0] hold_vec, elig, depart_vec;
    logic [NPAIR-1:0] thr_we, arr_clr, dep_clr;
    logic [LVL_W-1:0] thr_vec [NPAIR];
    logic [CNT_W-1:0] arr_vec [NPAIR];
    logic [CNT_W-1:0] dep_vec [NPAIR];
    logic             pk_valid;
    logic [IW-1:0]    pk_idx;
    logic [1:0]       grp;
    logic [IW-1:0]    pidx;

    assign grp  = reg_addr[AW-1:IW];
    assign pidx = reg_addr[IW-1:0];
    assign elig = in_rdy & ~hold_vec & ~out_full;

    for (genvar i = 0; i < NPAIR; i++) begin : g_pair
        localparam int TW = (i == NPAIR - 1) ? WIDE_W : NARROW_W;
        assign thr_we[i]  = reg_we && (grp == 2'd0) && (pidx == IW'(i));
        assign arr_clr[i] = reg_we && (grp == 2'd1) && (pidx == IW'(i));
        assign dep_clr[i] = reg_we && (grp == 2'd2) && (pidx == IW'(i));

        cfc_pair_gate #(
            .LVL_W (LVL_W),
            .THR_W (TW),
            .CNT_W (CNT_W)
        ) u_gate (
            .clk       (clk),
            .rst_n     (rst_n),
            .thr_we    (thr_we[i]),
            .arr_clr   (arr_clr[i]),
            .dep_clr   (dep_clr[i]),
            .thr_wdata (reg_wdata[LVL_W-1:0]),
            .level     (out_level[i*LVL_W +: LVL_W]),
            .arrive    (in_arrive[i]),
            .depart    (depart_vec[i]),
            .hold      (hold_vec[i]),
            .thr       (thr_vec[i]),
            .arr_cnt   (arr_vec[i]),
            .dep_cnt   (dep_vec[i])
        );
    end

    cfc_rr_pick #(
        .N  (NPAIR),
        .IW (IW)
    ) u_pick (
        .req   (elig),
        .last  (ctl_q.last),
        .valid (pk_valid),
        .idx   (pk_idx)
    );

    always_comb begin
        ctl_d      = ctl_q;
        in_pop     = '0;
        out_push   = '0;
        depart_vec = '0;
        out_data   = in_data[ctl_q.sel*DW +: DW];
        case (ctl_q.st)
            XF_IDLE: begin
                if (pk_valid) begin
                    ctl_d.st  = XF_MOVE;
                    ctl_d.sel = pk_idx;
                    ctl_d.wc  = '0;
                end
            end
            default: begin
                in_pop[ctl_q.sel]   = 1'b1;
                out_push[ctl_q.sel] = 1'b1;
                if (ctl_q.wc == LAST_WORD) begin
                    ctl_d.st              = XF_IDLE;
                    ctl_d.last            = ctl_q.sel;
                    depart_vec[ctl_q.sel] = 1'b1;
                end else begin
                    ctl_d.wc = ctl_q.wc + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st   <= XF_IDLE;
            ctl_q.sel  <= '0;
            ctl_q.last <= IW'(NPAIR - 1);
            ctl_q.wc   <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (int'(pidx) < NPAIR) begin
            case (grp)
                2'd0:    reg_rdata = 16'(thr_vec[pidx]);
                2'd1:    reg_rdata = arr_vec[pidx];
                2'd2:    reg_rdata = dep_vec[pidx];
                default: reg_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/cfc_chk.sv
module cfc_chk #(
    parameter int NPAIR      = 5,
    parameter int LVL_W      = 6,
    parameter int CELL_WORDS = 53
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NPAIR-1:0]       in_pop,
    input logic [NPAIR-1:0]       out_push,
    input logic [NPAIR-1:0]       out_full,
    input logic [NPAIR-1:0]       hold,
    input logic [LVL_W-1:0]       thr [NPAIR],
    input logic [NPAIR*LVL_W-1:0] level
);
    int run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        run_q <= 0;
        else if (|out_push) run_q <= run_q + 1;
        else               run_q <= 0;
    end

    AST_ONE_CELL: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(out_push)); // R7
    AST_POP_WITH_PUSH: assert property (@(posedge clk) disable iff (!rst_n) in_pop == out_push); // R6
    AST_CELL_SHORT: assert property (@(posedge clk) disable iff (!rst_n) (|out_push) |-> run_q < CELL_WORDS); // R6
    AST_CELL_WHOLE: assert property (@(posedge clk) disable iff (!rst_n) (!(|out_push) && run_q != 0) |-> run_q == CELL_WORDS); // R6

    for (genvar i = 0; i < NPAIR; i++) begin : g_p
        AST_HOLD_SET: assert property (@(posedge clk) disable iff (!rst_n) (level[i*LVL_W +: LVL_W] > thr[i]) |=> hold[i]); // R3
        AST_HOLD_CLR: assert property (@(posedge clk) disable iff (!rst_n) (level[i*LVL_W +: LVL_W] < thr[i]) |=> !hold[i]); // R4
        AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n) (level[i*LVL_W +: LVL_W] == thr[i]) |=> hold[i] == $past(hold[i])); // R4
        AST_NO_HELD_START: assert property (@(posedge clk) disable iff (!rst_n) $rose(out_push[i]) |-> (!$past(hold[i]) && !$past(out_full[i]))); // R5
    end
endmodule

bind cell_gate_ctrl cfc_chk #(
    .NPAIR      (NPAIR),
    .LVL_W      (LVL_W),
    .CELL_WORDS (CELL_WORDS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_pop   (in_pop),
    .out_push (out_push),
    .out_full (out_full),
    .hold     (hold_vec),
    .thr      (thr_vec),
    .level    (out_level)
);

// File: tb/sim_cell_gate_ctrl.sv
module sim_cell_gate_ctrl;
    localparam int NP = 5;
    localparam int DW = 8;
    localparam int CW = 4;
    localparam int LW = 6;
    localparam int AW = 5;
    // {port[3], thr[6], level[6], new cells[3], expected departures[3]}
    localparam int NV = 13;
    localparam logic [20:0] VEC [NV] = '{
        {3'd0, 6'd5,  6'd3,  3'd2, 3'd2},
        {3'd0, 6'd5,  6'd5,  3'd1, 3'd1},
        {3'd0, 6'd5,  6'd6,  3'd2, 3'd0},
        {3'd0, 6'd5,  6'd5,  3'd0, 3'd0},
        {3'd0, 6'd5,  6'd4,  3'd0, 3'd2},
        {3'd4, 6'd40, 6'd40, 3'd1, 3'd1},
        {3'd4, 6'd40, 6'd41, 3'd1, 3'd0},
        {3'd4, 6'd40, 6'd39, 3'd0, 3'd1},
        {3'd2, 6'd0,  6'd0,  3'd1, 3'd1},
        {3'd2, 6'd0,  6'd1,  3'd1, 3'd0},
        {3'd1, 6'd15, 6'd15, 3'd3, 3'd3},
        {3'd2, 6'd0,  6'd0,  3'd0, 3'd0},
        {3'd2, 6'd1,  6'd0,  3'd0, 3'd1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NP-1:0]    in_rdy, in_arrive = '0, in_pop, out_full = '0, out_push;
    logic [NP*DW-1:0] in_data;
    logic [NP*LW-1:0] out_level = '0;
    logic [DW-1:0]    out_data;
    logic             reg_we = 1'b0;
    logic [AW-1:0]    reg_addr = '0;
    logic [15:0]      reg_wdata = '0, reg_rdata;

    int checks = 0, fails = 0, done = 0;
    int cells_left [NP];
    int words [NP];
    int push_total = 0;
    int log_p [16];
    int log_n = 0;
    int exp_arr [NP];
    int exp_dep [NP];

    always #5 clk = ~clk;

    for (genvar i = 0; i < NP; i++) begin : g_q
        assign in_rdy[i] = cells_left[i] > 0;
        assign in_data[i*DW +: DW] = DW'(16 * (i + 1) + 5);
    end

    cell_gate_ctrl #(
        .NPAIR(NP), .DW(DW), .CELL_WORDS(CW), .NARROW_W(4), .WIDE_W(LW)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .in_rdy(in_rdy), .in_arrive(in_arrive),
        .in_data(in_data), .in_pop(in_pop), .out_full(out_full),
        .out_level(out_level), .out_push(out_push), .out_data(out_data),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // queue model and word-level checks, sampled mid-cycle
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < NP; i++) begin
                if (out_push[i]) begin
                    if (words[i] % CW == 0 && log_n < 16) begin
                        log_p[log_n] = i;
                        log_n++;
                    end
                    chk("R6 data", int'(out_data), 16 * (i + 1) + 5);
                    chk("R6 pop", int'(in_pop[i]), 1);
                    words[i]++;
                    push_total++;
                    if (words[i] % CW == 0) cells_left[i]--;
                end
            end
        end
    end

    task automatic wr(input int a, input int d);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = 16'(d);
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        @(posedge clk); #1;
        reg_addr = AW'(a);
        @(negedge clk);
        v = int'(reg_rdata);
    endtask

    task automatic set_lvl(input int p, input int v);
        @(posedge clk); #1;
        out_level[p*LW +: LW] = LW'(v);
    endtask

    task automatic give(input int p, input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #1;
            in_arrive[p] = 1'b1;
            cells_left[p]++;
        end
        @(posedge clk); #1;
        in_arrive = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int v, p, t, l, c, e, w0;
        for (int i = 0; i < NP; i++) begin
            cells_left[i] = 0; words[i] = 0; exp_arr[i] = 0; exp_dep[i] = 0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state, read through the R2 map
        for (int i = 0; i < NP; i++) begin
            rd(i, v);      chk("R1 R2 threshold", v, (i == NP - 1) ? 63 : 15);
            rd(8 + i, v);  chk("R1 arrival", v, 0);
            rd(16 + i, v); chk("R1 departure", v, 0);
        end
        chk("R1 no push", push_total, 0);

        // R9 threshold width, counter clear
        wr(0, 63);  rd(0, v); chk("R9 narrow mask", v, 15);
        wr(4, 42);  rd(4, v); chk("R9 wide load", v, 42);
        wr(4, 63);
        give(0, 2); exp_arr[0] += 2; exp_dep[0] += 2;
        repeat (20) @(posedge clk);
        rd(8, v);  chk("R8 arrival", v, 2);
        wr(8, 0);  rd(8, v); chk("R9 clear arrival", v, 0);
        wr(16, 0); rd(16, v); chk("R9 clear departure", v, 0);
        exp_arr[0] = 0; exp_dep[0] = 0;

        // vector table: R3 R4 R8 R10
        for (int n = 0; n < NV; n++) begin
            p = int'(VEC[n][20:18]); t = int'(VEC[n][17:12]);
            l = int'(VEC[n][11:6]);  c = int'(VEC[n][5:3]); e = int'(VEC[n][2:0]);
            wr(p, t);
            set_lvl(p, l);
            repeat (3) @(posedge clk);
            give(p, c);
            repeat (30) @(posedge clk);
            exp_arr[p] += c; exp_dep[p] += e;
            rd(16 + p, v); chk("R3 R4 R10 departures", v, exp_dep[p]);
            rd(8 + p, v);  chk("R8 arrivals", v, exp_arr[p]);
        end

        // R5: a full output queue is skipped
        set_lvl(3, 0);
        @(posedge clk); #1 out_full[3] = 1'b1;
        give(3, 1);
        repeat (30) @(posedge clk);
        rd(19, v); chk("R5 full skipped", v, 0);
        @(posedge clk); #1 out_full[3] = 1'b0;
        repeat (30) @(posedge clk);
        rd(19, v); chk("R5 full released", v, 1);

        // R6: a cell in flight completes after its pair becomes held
        wr(1, 15); set_lvl(1, 0);
        rd(17, w0);
        w0 = words[1];
        give(1, 2);
        while (!out_push[1]) @(negedge clk);
        out_level[1*LW +: LW] = LW'(20);
        repeat (40) @(posedge clk);
        rd(17, v); chk("R6 cell finished once", v, exp_dep[1] + 1);
        chk("R6 words of cell", words[1] - w0, CW);
        set_lvl(1, 0);
        repeat (30) @(posedge clk);
        rd(17, v); chk("R4 second cell after release", v, exp_dep[1] + 2);

        // R7: round robin between two backlogged pairs
        wr(0, 15); set_lvl(0, 0);
        repeat (3) @(posedge clk);
        log_n = 0;
        @(posedge clk); #1;
        cells_left[0] += 2; cells_left[1] += 2;
        repeat (50) @(posedge clk);
        chk("R7 cells moved", log_n, 4);
        chk("R7 alternate 0", int'(log_p[0] != log_p[1]), 1);
        chk("R7 alternate 1", int'(log_p[1] != log_p[2]), 1);
        chk("R7 alternate 2", int'(log_p[2] != log_p[3]), 1);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule